// File: doc/BRIEF.md
# Burst-of-Four Page Mode Sequencer

This block sequences the external accesses of a static memory bank. Each bank has its own page-mode bit. When a bank's bit is clear, a request produces one word access at the requested address. When the bit is set, a request produces four word accesses in a row. Only address bits [4:3] change across these accesses, counting 00, 01, 10, 11, so the four sequential words of one quad-word block are visited. The same rules apply to reads and writes.

A request is accepted while the block is idle. A burst request must start on a quad-word boundary. If it does not, the block refuses it: it raises an error pulse and makes no external access. Each word is held on the external bus for a programmable number of wait cycles plus one. A beat strobe marks the final cycle of each word so that the datapath can capture or advance its data. A last flag marks the final beat of a request.

Top module: `page_burst_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1 and `mem_rd`, `mem_wr`, `beat`, `last` and `err` are 0.
- R2: When the page-mode bit of the selected bank is 0, an accepted request makes exactly one access with `mem_addr` equal to `req_addr`, and its single beat carries `last`.
- R3: When the page-mode bit of the selected bank is 1 and `req_addr[4:3]` is 00, the request makes four accesses with `mem_addr[4:3]` equal to 00, 01, 10 and 11 in that order.
- R4: During a burst, every bit of `mem_addr` except bits [4:3] equals the same bit of the accepted `req_addr`.
- R5: A request to a page-mode bank with `req_addr[4:3]` not 00 sets `err` to 1 for one cycle, in the cycle after it is presented. It makes no access, and `req_ready` stays 1.
- R6: While an access is in progress, exactly one of `mem_rd` and `mem_wr` is 1: `mem_wr` when `req_write` was 1 at acceptance, `mem_rd` otherwise. Both are 0 when idle.
- R7: Each word stays on the bus for `wait_cycles`+1 cycles, with `wait_cycles` sampled at acceptance. `beat` is 1 only in the final cycle of each word.
- R8: `last` is 1 only together with the final beat of a request: beat 1 of a single access, beat 4 of a burst.
- R9: `req_ready` is 0 while a request is in progress. A `req_valid` presented then has no effect on the sequence being issued.
- R10: The page-mode bit is chosen per request by `req_bank`, so banks with different settings behave differently under the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_page_en | input | NBANK | Page-mode enable, one bit per bank |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank index |
| req_addr | input | AW | Start byte address |
| wait_cycles | input | WAIT_W | Extra cycles per word |
| req_ready | output | 1 | Idle, able to accept a request |
| mem_addr | output | AW | External address of current word |
| mem_rd | output | 1 | Read access in progress |
| mem_wr | output | 1 | Write access in progress |
| beat | output | 1 | Final cycle of a word |
| last | output | 1 | Final beat of the request |
| err | output | 1 | Misaligned burst refused |

## Verification
The bench sends single reads and writes to banks with page mode off, at addresses whose bits [4:3] are not zero. These show that a single access keeps the requested address rather than forcing the word index to zero. Aligned bursts with wait counts of 0 and 3 show the order of the word index, that the upper and byte-offset bits do not change, and that the beat spacing follows the wait count. Misaligned addresses sent to a page-mode bank are told apart from the same addresses sent to a single-mode bank by the error pulse and the absence of any access. A second request presented mid-burst shows that a busy sequencer ignores new input.

// File: rtl/page_burst_seq.sv
module page_burst_seq #(
  parameter int NBANK  = 4,
  parameter int AW     = 32,
  parameter int WAIT_W = 4,
  parameter int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBANK-1:0]  cfg_page_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [AW-1:0]     req_addr,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              req_ready,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              beat,
  output logic              last,
  output logic              err
);
  localparam logic [1:0] FINAL_IDX = 2'b11;

  logic              busy, burst_q, wr_q, err_q;
  logic [AW-1:0]     base_q;
  logic [1:0]        idx_q;
  logic [WAIT_W-1:0] wait_q, wcnt_q;

  logic sel_burst, misaligned, fin;

  assign sel_burst  = cfg_page_en[req_bank];
  assign misaligned = sel_burst && (req_addr[4:3] != 2'b00);
  assign fin        = !burst_q || (idx_q == FINAL_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      burst_q <= 1'b0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      base_q  <= '0;
      idx_q   <= '0;
      wait_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      err_q <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          if (misaligned) begin
            err_q <= 1'b1;
          end else begin
            busy    <= 1'b1;
            burst_q <= sel_burst;
            wr_q    <= req_write;
            base_q  <= req_addr;
            idx_q   <= sel_burst ? 2'b00 : req_addr[4:3];
            wait_q  <= wait_cycles;
            wcnt_q  <= wait_cycles;
          end
        end
      end else if (wcnt_q != '0) begin
        wcnt_q <= wcnt_q - 1'b1;
      end else if (fin) begin
        busy <= 1'b0;
      end else begin
        idx_q  <= idx_q + 2'b01;
        wcnt_q <= wait_q;
      end
    end
  end

  assign req_ready = !busy;
  assign mem_rd    = busy && !wr_q;
  assign mem_wr    = busy && wr_q;
  assign beat      = busy && (wcnt_q == '0);
  assign last      = beat && fin;
  assign err       = err_q;
  assign mem_addr  = busy ? {base_q[AW-1:5], idx_q, base_q[2:0]} : '0;
endmodule

// File: rtl/page_burst_seq_chk.sv
module page_burst_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          beat,
  input logic          last,
  input logic          err
);
  a_r6_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(mem_rd || mem_wr || beat));

  a_r5_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (req_ready && !mem_rd && !mem_wr));

  a_r8_last_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> beat);

  a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !last) |=> (mem_addr[4:3] == $past(mem_addr[4:3]) + 2'b01));

  a_r4_other_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !last) |=> ($stable(mem_addr[AW-1:5]) && $stable(mem_addr[2:0])));

  a_r7_hold_between_beats: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !beat) |=> $stable(mem_addr));

  a_r9_busy_until_last: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !last) |=> !req_ready);
endmodule

bind page_burst_seq page_burst_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .beat(beat), .last(last), .err(err)
);

// File: tb/page_burst_seq_tb.sv
module page_burst_seq_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    cfg_page_en = 4'b0101;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_bank = '0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    wait_cycles = '0;
  logic          req_ready, mem_rd, mem_wr, beat, last, err;
  logic [AW-1:0] mem_addr;

  always #5 clk = ~clk;

  page_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_page_en(cfg_page_en), .req_valid(req_valid),
    .req_write(req_write), .req_bank(req_bank), .req_addr(req_addr),
    .wait_cycles(wait_cycles), .req_ready(req_ready), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .beat(beat), .last(last), .err(err)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          wr;
    logic          lst;
    int            span;
  } beat_t;

  beat_t exp_q[$];
  int checks = 0, fails = 0, run = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected beats and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd || mem_wr) run++;
      if (beat) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", "unexpected beat", mem_addr, 0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          check(mem_addr == e.addr, "R2/R3/R4", "beat address", mem_addr, e.addr);
          check(mem_wr == e.wr && mem_rd == !e.wr, "R6", "direction", {mem_wr, mem_rd}, {e.wr, !e.wr});
          check(last == e.lst, "R8", "last flag", last, e.lst);
          check(run == e.span, "R7", "cycles per word", run, e.span);
        end
        run = 0;
      end
    end
  end

  task automatic do_req(input logic [1:0] bank, input logic [AW-1:0] addr,
                        input logic wr, input logic [3:0] w,
                        input logic page, input logic expect_err);
    while (!req_ready) @(negedge clk);
    if (!expect_err) begin
      if (page) begin
        for (int i = 0; i < 4; i++) begin
          beat_t e;
          e.addr = {addr[AW-1:5], 2'(i), addr[2:0]};
          e.wr = wr; e.lst = (i == 3); e.span = int'(w) + 1;
          exp_q.push_back(e);
        end
      end else begin
        beat_t e;
        e.addr = addr; e.wr = wr; e.lst = 1'b1; e.span = int'(w) + 1;
        exp_q.push_back(e);
      end
    end
    req_bank = bank; req_addr = addr; req_write = wr; wait_cycles = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_cycles = 4'd9;
    if (expect_err) begin
      check(err == 1'b1, "R5", "error pulse", err, 1);
      check(!mem_rd && !mem_wr, "R5", "no access", {mem_rd, mem_wr}, 0);
      check(req_ready == 1'b1, "R5", "stays ready", req_ready, 1);
      @(negedge clk);
      check(err == 1'b0, "R5", "error is one cycle", err, 0);
    end else begin
      check(req_ready == 1'b0, "R9", "busy after accept", req_ready, 0);
      check(err == 1'b0, "R5", "no error on valid request", err, 0);
    end
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !mem_rd && !mem_wr && !beat && !last && !err, "R1", "reset state",
          {req_ready, mem_rd, mem_wr, beat, last, err}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_rd && !mem_wr, "R1", "idle after reset", {req_ready, mem_rd, mem_wr}, 3'b100);

    // R2 single accesses on bank 1 (page mode off), index bits nonzero kept
    do_req(2'd1, 32'h1234_5A5B, 1'b0, 4'd0, 1'b0, 1'b0);
    do_req(2'd3, 32'hF000_0013, 1'b1, 4'd2, 1'b0, 1'b0);
    // R3 R4 bursts on banks 0 and 2
    do_req(2'd0, 32'h8765_43A5, 1'b0, 4'd0, 1'b1, 1'b0);
    do_req(2'd2, 32'h0000_0107, 1'b1, 4'd3, 1'b1, 1'b0);
    // R5 misaligned bursts refused
    do_req(2'd0, 32'h0000_0008, 1'b0, 4'd1, 1'b1, 1'b1);
    do_req(2'd2, 32'hABCD_EF18, 1'b1, 4'd0, 1'b1, 1'b1);
    // R10 same misaligned address on a single-mode bank is accepted
    do_req(2'd1, 32'h0000_0008, 1'b0, 4'd1, 1'b0, 1'b0);
    // R10 reconfigure bank 1 to page mode
    cfg_page_en = 4'b0010;
    do_req(2'd1, 32'h4000_0040, 1'b1, 4'd1, 1'b1, 1'b0);
    do_req(2'd0, 32'h4000_0050, 1'b0, 4'd0, 1'b0, 1'b0);

    // R9 request presented mid-burst is ignored
    fork
      do_req(2'd1, 32'h2222_2200, 1'b0, 4'd2, 1'b1, 1'b0);
      begin
        repeat (3) @(negedge clk);
        req_bank = 2'd0; req_addr = 32'h9999_9990; req_write = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    check(req_ready && !mem_rd && !mem_wr, "R9", "idle after ignored request",
          {req_ready, mem_rd, mem_wr}, 3'b100);
    check(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule